// File: doc/BRIEF.md
# Load-Use Stall Controller

This block guards a five-stage in-order pipeline against the one data dependency that forwarding cannot cover in time: a load whose destination register is read by the instruction directly behind it. While the dependent instruction sits in decode, the block compares its two source register numbers against the destination of the load in the execute-side pipeline register. On a match it holds the program counter and the fetch/decode register for one cycle and sends an all-zero control word into execute. The load then reaches the memory/writeback register, where the normal forwarding path can supply its value.

So that the stall can be watched over time, the block carries its own small pipeline: a program counter that steps by a fixed amount, a fetch/decode register holding the two source fields and the control word of the fetched instruction, and a decode/execute register holding the control word and the second source field, which also names the load's destination. Bit 0 of every control word is the memory-read flag. The fetch side is driven by whatever instruction store sits at the current PC.

Top module: `lu_stall_unit`

## Requirements
- R1: While `rst` is high at a rising edge, the PC, both fields and the control word of the decode register and the execute control word and register number all become zero, and `stall` is 0 with `pc_write` and `dec_write` at 1.
- R2: `stall` is 1 when bit 0 of `ex_ctrl` (memory-read) is 1, `ex_rt` is non-zero and `ex_rt` equals `dec_rs`.
- R3: `stall` is 1 when bit 0 of `ex_ctrl` is 1, `ex_rt` is non-zero and `ex_rt` equals `dec_rt`.
- R4: A load whose `ex_rt` is zero never raises `stall`, whatever the decode fields hold.
- R5: In a stall cycle `pc_write` is 0 and the PC keeps its value at the next edge, so the following instruction is fetched again.
- R6: In a stall cycle `dec_write` is 0 and `dec_rs`, `dec_rt` and `dec_ctrl` keep their values at the next edge, so the dependent instruction is decoded again.
- R7: After a stall cycle `ex_ctrl` is all zero (a bubble); `ex_rt` still takes `dec_rt`.
- R8: Without a stall, at the next edge the PC grows by `PC_STEP` (4 by default), the decode register loads the fetch inputs, and `ex_ctrl`/`ex_rt` take `dec_ctrl`/`dec_rt` unchanged.
- R9: A stall lasts exactly one cycle: `stall` is never 1 in two cycles in a row.
- R10: When bit 0 of `ex_ctrl` is 0, `stall` is 0 even if `ex_rt` matches a decode source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| fetch_rs | input | RW | First source register of the instruction at `pc` |
| fetch_rt | input | RW | Second source / load destination of the instruction at `pc` |
| fetch_ctrl | input | CW | Control word of the instruction at `pc`; bit 0 is memory-read |
| pc | output | PCW | Program counter |
| pc_write | output | 1 | PC update enable (0 during a stall) |
| dec_write | output | 1 | Decode register load enable (0 during a stall) |
| stall | output | 1 | Load-use hazard present this cycle |
| dec_rs | output | RW | First source field in the decode register |
| dec_rt | output | RW | Second source field in the decode register |
| dec_ctrl | output | CW | Control word in the decode register |
| ex_ctrl | output | CW | Control word in the execute register |
| ex_rt | output | RW | Second source / destination field in the execute register |

## Verification
The functions that meet in one cycle are hazard detection and bubble insertion on a dependent instruction that is itself a load: while it is held in decode the bubble clears the execute memory-read flag, and one cycle later the same instruction moves to execute and is checked against the next fetched instruction. The instruction store places load chains, loads whose destination matches both source fields, and loads with register zero next to one another and mixes them with random words. Every cycle a bench model of the pipeline, stepped from the requirements, predicts the PC, both registers and the stall signals, and any divergence is reported against the requirement that governs that cycle.

// File: rtl/lu_pkg.sv
package lu_pkg;
  // Number of source operands compared in decode.
  localparam int unsigned NSRC = 2;
  // Bit of the control word that marks a memory read.
  localparam int unsigned MEMRD_BIT = 0;

  typedef enum int unsigned {
    SRC_FIRST  = 0,
    SRC_SECOND = 1
  } src_sel_e;
endpackage

// File: rtl/lu_hazard_detect.sv
module lu_hazard_detect #(
  parameter int unsigned RW = 5,
  parameter int unsigned NSRC = 2
) (
  input  logic                     ld_read,
  input  logic [RW-1:0]            ld_dst,
  input  logic [NSRC-1:0][RW-1:0]  src,
  output logic                     hazard
);
  logic [NSRC-1:0] hit;

  for (genvar g = 0; g < NSRC; g++) begin : g_cmp
    assign hit[g] = (src[g] == ld_dst);
  end

  // Register zero is hard-wired, so a load into it creates no dependency.
  assign hazard = ld_read && (ld_dst != '0) && (|hit);
endmodule

// File: rtl/lu_pc_reg.sv
module lu_pc_reg #(
  parameter int unsigned PCW = 32,
  parameter int unsigned PC_STEP = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           we,
  output logic [PCW-1:0] pc
);
  localparam logic [PCW-1:0] STEP = PCW'(PC_STEP);

  always_ff @(posedge clk) begin
    if (rst)     pc <= '0;
    else if (we) pc <= pc + STEP;
  end
endmodule

// File: rtl/lu_dec_reg.sv
module lu_dec_reg #(
  parameter int unsigned RW = 5,
  parameter int unsigned CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [RW-1:0] rs_in,
  input  logic [RW-1:0] rt_in,
  input  logic [CW-1:0] ctrl_in,
  output logic [RW-1:0] rs_q,
  output logic [RW-1:0] rt_q,
  output logic [CW-1:0] ctrl_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      rs_q   <= '0;
      rt_q   <= '0;
      ctrl_q <= '0;
    end else if (we) begin
      rs_q   <= rs_in;
      rt_q   <= rt_in;
      ctrl_q <= ctrl_in;
    end
  end
endmodule

// File: rtl/lu_ex_reg.sv
module lu_ex_reg #(
  parameter int unsigned RW = 5,
  parameter int unsigned CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bubble,
  input  logic [RW-1:0] rt_in,
  input  logic [CW-1:0] ctrl_in,
  output logic [RW-1:0] rt_q,
  output logic [CW-1:0] ctrl_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      rt_q   <= '0;
      ctrl_q <= '0;
    end else begin
      rt_q   <= rt_in;
      ctrl_q <= bubble ? '0 : ctrl_in;
    end
  end
endmodule

// File: rtl/lu_stall_unit.sv
module lu_stall_unit #(
  parameter int unsigned RW = 5,
  parameter int unsigned CW = 8,
  parameter int unsigned PCW = 32,
  parameter int unsigned PC_STEP = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [RW-1:0]  fetch_rs,
  input  logic [RW-1:0]  fetch_rt,
  input  logic [CW-1:0]  fetch_ctrl,
  output logic [PCW-1:0] pc,
  output logic           pc_write,
  output logic           dec_write,
  output logic           stall,
  output logic [RW-1:0]  dec_rs,
  output logic [RW-1:0]  dec_rt,
  output logic [CW-1:0]  dec_ctrl,
  output logic [CW-1:0]  ex_ctrl,
  output logic [RW-1:0]  ex_rt
);
  import lu_pkg::*;

  logic [NSRC-1:0][RW-1:0] dec_src;
  logic hazard;

  assign dec_src[SRC_FIRST]  = dec_rs;
  assign dec_src[SRC_SECOND] = dec_rt;

  lu_hazard_detect #(.RW(RW), .NSRC(NSRC)) u_detect (
    .ld_read (ex_ctrl[MEMRD_BIT]),
    .ld_dst  (ex_rt),
    .src     (dec_src),
    .hazard  (hazard)
  );

  assign stall     = hazard;
  assign pc_write  = !hazard;
  assign dec_write = !hazard;

  lu_pc_reg #(.PCW(PCW), .PC_STEP(PC_STEP)) u_pc (
    .clk (clk),
    .rst (rst),
    .we  (pc_write),
    .pc  (pc)
  );

  lu_dec_reg #(.RW(RW), .CW(CW)) u_dec (
    .clk     (clk),
    .rst     (rst),
    .we      (dec_write),
    .rs_in   (fetch_rs),
    .rt_in   (fetch_rt),
    .ctrl_in (fetch_ctrl),
    .rs_q    (dec_rs),
    .rt_q    (dec_rt),
    .ctrl_q  (dec_ctrl)
  );

  lu_ex_reg #(.RW(RW), .CW(CW)) u_ex (
    .clk     (clk),
    .rst     (rst),
    .bubble  (hazard),
    .rt_in   (dec_rt),
    .ctrl_in (dec_ctrl),
    .rt_q    (ex_rt),
    .ctrl_q  (ex_ctrl)
  );
endmodule

// File: rtl/lu_stall_chk.sv
module lu_stall_chk #(
  parameter int unsigned RW = 5,
  parameter int unsigned CW = 8,
  parameter int unsigned PCW = 32,
  parameter int unsigned PC_STEP = 4
) (
  input logic           clk,
  input logic           rst,
  input logic [PCW-1:0] pc,
  input logic           stall,
  input logic [RW-1:0]  dec_rs,
  input logic [RW-1:0]  dec_rt,
  input logic [CW-1:0]  dec_ctrl,
  input logic [CW-1:0]  ex_ctrl,
  input logic [RW-1:0]  ex_rt
);
  localparam logic [PCW-1:0] STEP = PCW'(PC_STEP);

  // R2
  rs_match_stall_chk: assert property (@(posedge clk) disable iff (rst)
    (ex_ctrl[0] && ex_rt != '0 && ex_rt == dec_rs) |-> stall);
  // R3
  rt_match_stall_chk: assert property (@(posedge clk) disable iff (rst)
    (ex_ctrl[0] && ex_rt != '0 && ex_rt == dec_rt) |-> stall);
  // R4
  zero_dst_chk: assert property (@(posedge clk) disable iff (rst)
    (ex_rt == '0) |-> !stall);
  // R10
  no_read_chk: assert property (@(posedge clk) disable iff (rst)
    !ex_ctrl[0] |-> !stall);
  // R5
  pc_hold_chk: assert property (@(posedge clk) disable iff (rst)
    stall |=> (pc == $past(pc)));
  // R6
  dec_hold_chk: assert property (@(posedge clk) disable iff (rst)
    stall |=> (dec_rs == $past(dec_rs) && dec_rt == $past(dec_rt) && dec_ctrl == $past(dec_ctrl)));
  // R7
  bubble_chk: assert property (@(posedge clk) disable iff (rst)
    stall |=> (ex_ctrl == '0 && ex_rt == $past(dec_rt)));
  // R9
  single_stall_chk: assert property (@(posedge clk) disable iff (rst)
    stall |=> !stall);
  // R8
  advance_chk: assert property (@(posedge clk) disable iff (rst)
    !stall |=> (pc == $past(pc) + STEP && ex_ctrl == $past(dec_ctrl)));
endmodule

bind lu_stall_unit lu_stall_chk #(.RW(RW), .CW(CW), .PCW(PCW), .PC_STEP(PC_STEP)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .pc       (pc),
  .stall    (stall),
  .dec_rs   (dec_rs),
  .dec_rt   (dec_rt),
  .dec_ctrl (dec_ctrl),
  .ex_ctrl  (ex_ctrl),
  .ex_rt    (ex_rt)
);

// File: tb/lu_stall_unit_tb.sv
module lu_stall_unit_tb;
  localparam int RW = 5;
  localparam int CW = 8;
  localparam int PCW = 32;
  localparam int NPROG = 64;
  localparam int NCYC = 400;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic [RW-1:0]  fetch_rs, fetch_rt, dec_rs, dec_rt, ex_rt;
  logic [CW-1:0]  fetch_ctrl, dec_ctrl, ex_ctrl;
  logic [PCW-1:0] pc;
  logic pc_write, dec_write, stall;

  logic [RW-1:0] p_rs [NPROG];
  logic [RW-1:0] p_rt [NPROG];
  logic [CW-1:0] p_ct [NPROG];

  always_comb begin
    fetch_rs   = p_rs[pc[7:2]];
    fetch_rt   = p_rt[pc[7:2]];
    fetch_ctrl = p_ct[pc[7:2]];
  end

  lu_stall_unit u_dut (
    .clk(clk), .rst(rst), .fetch_rs(fetch_rs), .fetch_rt(fetch_rt), .fetch_ctrl(fetch_ctrl),
    .pc(pc), .pc_write(pc_write), .dec_write(dec_write), .stall(stall),
    .dec_rs(dec_rs), .dec_rt(dec_rt), .dec_ctrl(dec_ctrl), .ex_ctrl(ex_ctrl), .ex_rt(ex_rt)
  );

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  // model state
  logic [PCW-1:0] m_pc;
  logic [RW-1:0]  m_drs, m_drt, m_ert;
  logic [CW-1:0]  m_dct, m_ect;
  bit m_rst, m_prev_stall;

  task automatic chk(input string tag, input string what, input longint act, input longint exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic bit m_hazard();
    return m_ect[0] && (m_ert != 0) && (m_ert == m_drs || m_ert == m_drt);
  endfunction

  task automatic fill_prog();
    void'($urandom(32'd20240611));
    for (int i = 0; i < NPROG; i++) begin
      p_rs[i] = RW'($urandom % 4);
      p_rt[i] = RW'($urandom % 4);
      p_ct[i] = CW'($urandom);
      p_ct[i][0] = (($urandom % 3) == 0);
    end
    // directed corners
    p_rt[0] = 5; p_ct[0] = 8'h81; p_rs[0] = 1;   // load into 5
    p_rs[1] = 5; p_rt[1] = 2; p_ct[1] = 8'h3C;   // R2 first source match
    p_rt[2] = 6; p_ct[2] = 8'h41; p_rs[2] = 3;   // load into 6
    p_rs[3] = 1; p_rt[3] = 6; p_ct[3] = 8'h12;   // R3 second source match
    p_rt[4] = 0; p_ct[4] = 8'hFF; p_rs[4] = 0;   // load into zero
    p_rs[5] = 0; p_rt[5] = 0; p_ct[5] = 8'h10;   // R4 no stall
    p_rt[6] = 7; p_ct[6] = 8'h01; p_rs[6] = 2;   // load into 7
    p_rs[7] = 7; p_rt[7] = 7; p_ct[7] = 8'h05;   // dependent load, both match
    p_rs[8] = 7; p_rt[8] = 1; p_ct[8] = 8'h20;   // depends on load 7
    p_rt[9] = 9; p_ct[9] = 8'hFE; p_rs[9] = 4;   // non-load into 9
    p_rs[10] = 9; p_rt[10] = 9; p_ct[10] = 8'h00; // R10 no stall
  endtask

  task automatic check_all();
    bit hz = m_hazard();
    string ts, tp, td, te;
    if (m_rst) begin ts = "R1"; tp = "R1"; td = "R1"; te = "R1"; end
    else begin
      if (hz) ts = (m_ert == m_drs) ? "R2" : "R3";
      else if (!m_ect[0]) ts = "R10";
      else if (m_ert == 0) ts = "R4";
      else ts = "R8";
      tp = m_prev_stall ? "R5" : "R8";
      td = m_prev_stall ? "R6" : "R8";
      te = m_prev_stall ? "R7" : "R8";
    end
    chk(ts, "stall", stall, hz);
    chk(hz ? "R5" : ts, "pc_write", pc_write, !hz);
    chk(hz ? "R6" : ts, "dec_write", dec_write, !hz);
    chk(tp, "pc", pc, m_pc);
    chk(td, "dec_rs", dec_rs, m_drs);
    chk(td, "dec_rt", dec_rt, m_drt);
    chk(td, "dec_ctrl", dec_ctrl, m_dct);
    chk(te, "ex_ctrl", ex_ctrl, m_ect);
    chk(te, "ex_rt", ex_rt, m_ert);
    if (!m_rst) chk("R9", "back-to-back stall", (stall && m_prev_stall), 0);
  endtask

  task automatic step_model(input bit rst_now);
    bit hz = m_hazard();
    int idx = int'(m_pc[7:2]);
    if (rst_now) begin
      m_pc = 0; m_drs = 0; m_drt = 0; m_dct = 0; m_ect = 0; m_ert = 0;
      m_prev_stall = 0; m_rst = 1;
    end else begin
      m_ert = m_drt;
      m_ect = hz ? '0 : m_dct;
      if (!hz) begin
        m_drs = p_rs[idx]; m_drt = p_rt[idx]; m_dct = p_ct[idx];
        m_pc = m_pc + 4;
      end
      m_prev_stall = hz;
      m_rst = 0;
    end
  endtask

  initial begin
    fill_prog();
    m_rst = 0;
    for (int c = 0; c < NCYC; c++) begin
      @(negedge clk);
      if (c >= 1) check_all();
      if (c == 3) rst = 1'b0;
      step_model(rst);
    end
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(4 * 5000);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule